// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block takes 32 interrupt request lines and latches each one into a source-pending register. A per-source mask enables or blocks each source. One chosen source can be sent to a fast-interrupt output, and all other sources contend for the normal interrupt output. The normal path chooses one unmasked pending source and records it as a single set bit in an interrupt-pending register. An offset register gives the binary index of that bit, so a handler can branch on it without scanning bits.

Software uses a small synchronous register bus. The source-pending and interrupt-pending registers are both cleared by writing ones. A handler first clears the source bit and then clears the interrupt-pending bit. Aggregated groups fed by downstream sub-controllers are ordinary request inputs here and are handled as level requests. Source positions 6 and 24 are unused.

Top module: `intr_ctrl`

## Requirements
- R1: After reset, the mask register reads all ones. The source-pending, mode and interrupt-pending registers read zero, the offset reads zero, and both irq_o and fiq_o are low.
- R2: A request on any bit other than 6 or 24 sets that bit of source-pending at the next clock edge, whether or not it is masked. Bits 6 and 24 never become set.
- R3: Writing to address 0 clears each source-pending bit whose data bit is 1 and leaves bits written with 0 unchanged. If a request arrives in the same cycle as the clear of its bit, the bit stays set.
- R4: Address 1 is the mask register, read/write. A mask bit of 1 stops its source from entering interrupt-pending and from driving fiq_o. A mask bit of 0 enables the source.
- R5: When interrupt-pending is zero, the lowest-numbered source that is pending, unmasked and not routed to the fast output is loaded into interrupt-pending as one set bit at the next edge. While interrupt-pending is nonzero, it does not change except through R6. irq_o is high exactly while interrupt-pending is nonzero.
- R6: Writing to address 3 clears each interrupt-pending bit whose data bit is 1. If another candidate is waiting, it is loaded at the edge after the clear.
- R7: Address 4 is read-only. It returns the binary index of the set interrupt-pending bit, and zero when interrupt-pending is empty.
- R8: Address 2 is the mode register. It holds at most one set bit. A write keeps only the lowest set bit of the written data. The selected source drives fiq_o while it is pending and unmasked, and it never enters interrupt-pending. Writing zero returns that source to the normal path.
- R9: Reads return source-pending at address 0, mask at 1, mode at 2, interrupt-pending at 3 and offset at 4. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Interrupt request lines, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The assertions assume that requests and bus signals are synchronous to clk_i. They also assume that interrupt-pending changes only through its own clear address, so the hold check treats any other write as having no effect on it. The stimulus changes request lines and bus fields only on falling edges. It holds each write strobe for exactly one rising edge and asserts overlapping requests and clears in the same cycle only when it is testing request precedence. Masks are set before unmasked requests arrive, so the bench knows each selection in advance.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_SRC_PEND = 3'd0,
    RA_MASK     = 3'd1,
    RA_MODE     = 3'd2,
    RA_INT_PEND = 3'd3,
    RA_OFFSET   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/intc_src_latch.sv
module intc_src_latch #(
  parameter int unsigned N   = 32,
  parameter logic [N-1:0] RSV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] live;

  assign live = req_i & ~RSV;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | live;
  end

  assign pend_o = pend_q;

  p_req_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|live) |=> ((pend_q & $past(live)) == $past(live)));

  p_w1c_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~req_i)) |=> ((pend_q & $past(clr_i & ~req_i)) == '0));
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] grant_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign grant_o[i]  = cand_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | cand_i[i];
  end
endmodule

// File: rtl/intc_enc.sv
module intc_enc #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  onehot_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_i[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned       N_SRC   = 32,
  parameter logic [N_SRC-1:0]  RSV_MAP = 32'h0100_0040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [N_SRC-1:0] src_pend, mask_q, mode_q, ipend_q;
  logic [N_SRC-1:0] src_clr, cand, grant, mode_pick;
  logic [IDX_W-1:0] offset;
  logic             wr_src, wr_mask, wr_mode, wr_ipend;

  assign wr_src   = wr_en_i && (addr_i == RA_SRC_PEND);
  assign wr_mask  = wr_en_i && (addr_i == RA_MASK);
  assign wr_mode  = wr_en_i && (addr_i == RA_MODE);
  assign wr_ipend = wr_en_i && (addr_i == RA_INT_PEND);
  assign src_clr  = wr_src ? wdata_i : '0;

  intc_src_latch #(.N(N_SRC), .RSV(RSV_MAP)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .clr_i  (src_clr),
    .pend_o (src_pend)
  );

  // keep only the lowest set bit on mode writes
  intc_pick #(.N(N_SRC)) u_mode_pick (
    .cand_i  (wdata_i),
    .grant_o (mode_pick)
  );

  assign cand = src_pend & ~mask_q & ~mode_q;

  intc_pick #(.N(N_SRC)) u_irq_pick (
    .cand_i  (cand),
    .grant_o (grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      mode_q <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata_i;
      if (wr_mode) mode_q <= mode_pick;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ipend_q <= '0;
    else if (ipend_q == '0)     ipend_q <= grant;
    else if (wr_ipend)          ipend_q <= ipend_q & ~wdata_i;
  end

  intc_enc #(.N(N_SRC), .IW(IDX_W)) u_enc (
    .onehot_i (ipend_q),
    .idx_o    (offset)
  );

  assign irq_o = |ipend_q;
  assign fiq_o = |(src_pend & ~mask_q & mode_q);

  always_comb begin
    case (addr_i)
      RA_SRC_PEND: rdata_o = src_pend;
      RA_MASK:     rdata_o = mask_q;
      RA_MODE:     rdata_o = mode_q;
      RA_INT_PEND: rdata_o = ipend_q;
      RA_OFFSET:   rdata_o = {{(N_SRC-IDX_W){1'b0}}, offset};
      default:     rdata_o = '0;
    endcase
  end

  p_ipend_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ipend_q));

  p_ipend_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipend_q != '0 && !wr_ipend) |=> $stable(ipend_q));

  p_load_unmasked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((ipend_q & $past(mask_q | mode_q)) == '0));

  p_mode_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_q));

  p_offset_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ipend_q[offset]);
endmodule

// File: tb/intr_ctrl_test.sv
module intr_ctrl_test;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         wr_en_i = 1'b0;
  logic [2:0]   addr_i = '0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic         irq_o, fiq_o;

  intr_ctrl uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin : monitor
    item_t it;
    logic [31:0] act;
    #1;
    while (sb.size() > 0) begin
      it  = sb.pop_front();
      act = (it.kind == 0) ? rdata_o : {30'd0, irq_o, fiq_o};
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    wr_en_i = 1'b0;
    addr_i  = a;
    sb.push_back('{0, e, tag});
  endtask

  task automatic expect_pins(input logic i, input logic f, input string tag);
    @(negedge clk);
    sb.push_back('{1, {30'd0, i, f}, tag});
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d,
                           input logic [31:0] r = '0);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; req_i = r;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0; req_i = '0;
  endtask

  task automatic pulse(input logic [31:0] r);
    @(negedge clk);
    req_i = r;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    expect_reg(3'd1, 32'hFFFF_FFFF, "R1 mask");
    expect_reg(3'd0, 32'h0, "R1 src_pend");
    expect_reg(3'd2, 32'h0, "R1 mode");
    expect_reg(3'd3, 32'h0, "R1 int_pend");
    expect_reg(3'd4, 32'h0, "R1 offset");
    expect_pins(1'b0, 1'b0, "R1 pins");

    // R2 latch while masked, reserved bits ignored; R4 masked gives no irq
    pulse(32'h0100_0048);
    expect_reg(3'd0, 32'h0000_0008, "R2 latch masked, reserved dropped");
    expect_reg(3'd3, 32'h0, "R4 masked source not serviced");
    expect_pins(1'b0, 1'b0, "R4 pins masked");

    // R4/R5/R7 unmask bits 3,5
    bus_write(3'd1, 32'hFFFF_FFD7);
    expect_reg(3'd3, 32'h0000_0008, "R5 load bit3");
    expect_reg(3'd4, 32'd3, "R7 offset 3");
    expect_pins(1'b1, 1'b0, "R5 irq high");

    // R5 hold while nonempty
    pulse(32'h0000_0020);
    expect_reg(3'd0, 32'h0000_0028, "R2 second source");
    expect_reg(3'd3, 32'h0000_0008, "R5 hold");

    // R3/R6 service sequence
    bus_write(3'd0, 32'h0000_0008);
    bus_write(3'd3, 32'h0000_0008);
    expect_reg(3'd3, 32'h0000_0020, "R6 next loaded");
    expect_reg(3'd4, 32'd5, "R7 offset 5");
    expect_reg(3'd0, 32'h0000_0020, "R3 zero bits untouched");

    // R5 lowest wins on simultaneous arrival
    bus_write(3'd0, 32'h0000_0020);
    bus_write(3'd3, 32'h0000_0020);
    pulse(32'h0000_0028);
    expect_reg(3'd3, 32'h0000_0008, "R5 lowest first");
    bus_write(3'd0, 32'h0000_0008);
    bus_write(3'd3, 32'h0000_0008);
    expect_reg(3'd3, 32'h0000_0020, "R6 then bit5");
    bus_write(3'd0, 32'h0000_0020);
    bus_write(3'd3, 32'h0000_0020);
    expect_pins(1'b0, 1'b0, "R6 all cleared");

    // R3 request wins over clear
    pulse(32'h0000_0020);
    bus_write(3'd0, 32'h0000_0020, 32'h0000_0020);
    expect_reg(3'd0, 32'h0000_0020, "R3 request beats clear");
    bus_write(3'd0, 32'h0000_0020);
    expect_reg(3'd0, 32'h0, "R3 plain clear");
    bus_write(3'd3, 32'h0000_0020);
    expect_pins(1'b0, 1'b0, "R6 idle");

    // R8 fast routing
    bus_write(3'd2, 32'h0000_0030);
    expect_reg(3'd2, 32'h0000_0010, "R8 lowest bit kept");
    bus_write(3'd1, 32'hFFFF_FFC7);
    pulse(32'h0000_0010);
    expect_pins(1'b0, 1'b1, "R8 fiq asserted");
    expect_reg(3'd3, 32'h0, "R8 bypasses int_pend");
    bus_write(3'd1, 32'hFFFF_FFD7);
    expect_pins(1'b0, 1'b0, "R4 mask blocks fiq");
    bus_write(3'd1, 32'hFFFF_FFC7);
    expect_pins(1'b0, 1'b1, "R8 fiq again");
    bus_write(3'd2, 32'h0);
    expect_pins(1'b1, 1'b0, "R8 back to irq");
    expect_reg(3'd4, 32'd4, "R7 offset 4");

    // R2 reserved bits stay clear even when unmasked
    bus_write(3'd1, 32'h0);
    pulse(32'h0100_0040);
    expect_reg(3'd0, 32'h0000_0010, "R2 reserved unmasked");
    expect_reg(3'd3, 32'h0000_0010, "R5 unchanged");

    // R9 map and R8 multi-bit write
    expect_reg(3'd1, 32'h0, "R9 mask readback");
    expect_reg(3'd5, 32'h0, "R9 addr5");
    expect_reg(3'd7, 32'h0, "R9 addr7");
    bus_write(3'd2, 32'h8000_0005);
    expect_reg(3'd2, 32'h0000_0001, "R8 multi-bit write");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule